// File: doc/BRIEF.md
# Rank-Size Configurable SDRAM Address Mapper

This block converts the linear byte address of a 64-byte block request into the values an SDRAM command needs. It produces one of four active-low rank chip selects, two internal-bank bits, and a multiplexed 14-line SDRAM address bus. A three-bit size code selects the capacity of one rank, from 512 KB up to 16 MB. That code decides which address bits pick the rank and which address bits form the row. A phase input selects what the bus carries: the row value for an activate command, or the column value for a read or write command.

The request, size code and phase are captured in one register stage. The outputs are derived combinationally from those registers, so each output reflects the inputs present at the preceding rising clock edge. A request qualifier (`req_valid`) marks a request. The mapper never applies back-pressure and has no ready signal, so a request is accepted on every cycle in which it is presented. A cycle without a request leaves the SDRAM side idle. Refresh, command timing and data transfer are handled elsewhere.

Top module: `sdram_addr_map`

## Requirements
- R1: Every output follows the inputs sampled at the previous rising clock edge. A change on an input has no effect on any output until the next rising edge.
- R2: During reset, and in every cycle whose sampled `req_valid` is 0, all four chip selects are high, the address bus is all zeros and both bank bits are 0.
- R3: Size code k (0=512 KB, 1=1 MB, 2=2 MB, 3=4 MB, 4=8 MB, 5=16 MB) takes the rank number from address bits [20+k:19+k]. Only the chip select at that index is driven low. Address bits above the rank field have no effect, so the rank number wraps modulo four.
- R4: `sd_bank[0]` equals address bit 5. `sd_bank[1]` equals address bit 11 for the 8 MB and 16 MB sizes and is 0 for all other sizes.
- R5: In the column phase (`req_col_phase`=1), bus lines 7..0 carry {addr[10:6], addr[4:2]}, with addr[10] on line 7. Lines 11..8 are 0.
- R6: In the row phase for sizes 512 KB to 4 MB (k=0..3), bus lines [7+k:0] carry addr[18+k:11]. Every line above 7+k is 0.
- R7: In the row phase, bus lines 10..0 carry addr[22:12] at 8 MB and addr[23:13] at 16 MB.
- R8: At 8 MB and 16 MB, bus line 12 carries addr[11] in both phases. At all smaller sizes it is 0.
- R9: Bus line 13 carries addr[12] only in the row phase at 16 MB. In every other case it is 0.
- R10: The unused size codes 6 and 7 map exactly as code 5 (16 MB).
- R11: Address bits 1..0 (the byte offset within a word) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 26 | Linear byte address of the block |
| req_size | input | 3 | Rank-size code |
| req_col_phase | input | 1 | 1 selects column value, 0 selects row value |
| sd_cs_n | output | 4 | Active-low rank chip selects |
| sd_addr | output | 14 | Multiplexed SDRAM address bus |
| sd_bank | output | 2 | Internal bank select bits |

## Verification
The bench walks every size code through every rank, both phases and patterns that set alternate bits. This exposes a rank or row field that is off by one position, which would show up as the wrong chip select or a row shifted by one. It checks lines 12 and 13 at each size boundary: a design that gated them wrongly would leak address bits onto lines that must stay low, or would keep line 13 active in the column phase. It also drives addresses with high bits and byte-offset bits set, so that any decode that fails to wrap modulo four, or that leaks the byte offset, produces a wrong output. The reserved size codes are exercised as well, to catch a design that lets them fall through to a small rank size.

// File: rtl/sdram_map_pkg.sv
package sdram_map_pkg;
  // Rank-size code values
  typedef enum logic [2:0] {
    SZ_512K = 3'd0,
    SZ_1M   = 3'd1,
    SZ_2M   = 3'd2,
    SZ_4M   = 3'd3,
    SZ_8M   = 3'd4,
    SZ_16M  = 3'd5
  } rank_size_e;

  localparam int SIZE_W      = 3;
  localparam int BANK_LO_BIT = 5;   // splits a block between internal banks
  localparam int WORD_LSB    = 2;
  localparam int WORD_W      = 3;
  localparam int COL_HI_LSB  = 6;
  localparam int COL_HI_W    = 5;
  localparam int COL_W       = COL_HI_W + WORD_W;
  localparam int ROW_LSB     = 11;
  localparam int ROW_MIN_W   = 8;   // row width at the smallest size
  localparam int ROW_MAX_W   = 11;  // lines 10..0
  localparam int RANK_LSB    = 19;  // rank field base at smallest size
  localparam int LINE_HI0    = 12;
  localparam int LINE_HI1    = 13;

  // Reserved codes behave as the largest size
  function automatic rank_size_e clamp_size(input logic [SIZE_W-1:0] code);
    return (code > SZ_16M) ? SZ_16M : rank_size_e'(code);
  endfunction
endpackage

// File: rtl/sdram_in_reg.sv
module sdram_in_reg
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_col,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output rank_size_e        q_size,
  output logic              q_col
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_size  <= SZ_512K;
      q_col   <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_addr  <= in_addr;
      q_size  <= clamp_size(in_size);
      q_col   <= in_col;
    end
  end
endmodule

// File: rtl/sdram_rank_dec.sv
module sdram_rank_dec
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int NUM_RANKS = 4
) (
  input  logic                 valid,
  input  logic [ADDR_W-1:0]    addr,
  input  rank_size_e           size,
  output logic [NUM_RANKS-1:0] cs_n
);
  localparam int RANK_W = $clog2(NUM_RANKS);

  logic [RANK_W-1:0] rank_sel;
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted  = addr >> (RANK_LSB + int'(size));
    rank_sel = shifted[RANK_W-1:0];
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cs
    assign cs_n[r] = !(valid && (rank_sel == RANK_W'(r)));
  end
endmodule

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int BUS_W  = 14
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  rank_size_e        size,
  input  logic              col_phase,
  output logic [BUS_W-1:0]  bus,
  output logic [1:0]        bank
);
  logic             big;
  logic [BUS_W-1:0] row_v, col_v, row_mask;
  logic [ADDR_W-1:0] row_src;
  int unsigned      shamt, row_w;

  always_comb begin
    big   = (size >= SZ_8M);
    shamt = big ? (ROW_LSB + int'(size) - int'(SZ_4M)) : ROW_LSB;
    row_w = big ? ROW_MAX_W : (ROW_MIN_W + int'(size));
    row_mask = BUS_W'((1 << row_w) - 1);
    row_src  = addr >> shamt;

    row_v = row_src[BUS_W-1:0] & row_mask;
    if (big)
      row_v[LINE_HI0] = addr[ROW_LSB];
    if (size == SZ_16M)
      row_v[LINE_HI1] = addr[ROW_LSB+1];

    col_v = '0;
    col_v[COL_W-1:WORD_W] = addr[COL_HI_LSB +: COL_HI_W];
    col_v[WORD_W-1:0]     = addr[WORD_LSB +: WORD_W];
    if (big)
      col_v[LINE_HI0] = addr[ROW_LSB];
  end

  always_comb begin
    if (!valid) begin
      bus  = '0;
      bank = '0;
    end else begin
      bus     = col_phase ? col_v : row_v;
      bank[0] = addr[BANK_LO_BIT];
      bank[1] = big & addr[ROW_LSB];
    end
  end
endmodule

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int BUS_W     = 14,
  parameter int NUM_RANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_col_phase,
  output logic [NUM_RANKS-1:0] sd_cs_n,
  output logic [BUS_W-1:0]     sd_addr,
  output logic [1:0]           sd_bank
);
  logic              q_valid;
  logic [ADDR_W-1:0] q_addr;
  rank_size_e        q_size;
  logic              q_col;

  sdram_in_reg #(.ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_addr(req_addr), .in_size(req_size), .in_col(req_col_phase),
    .q_valid(q_valid), .q_addr(q_addr), .q_size(q_size), .q_col(q_col)
  );

  sdram_rank_dec #(.ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS)) u_rank (
    .valid(q_valid), .addr(q_addr), .size(q_size), .cs_n(sd_cs_n)
  );

  sdram_addr_mux #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_mux (
    .valid(q_valid), .addr(q_addr), .size(q_size), .col_phase(q_col),
    .bus(sd_addr), .bank(sd_bank)
  );
endmodule

// File: rtl/sdram_addr_map_chk.sv
module sdram_addr_map_chk #(
  parameter int ADDR_W    = 26,
  parameter int BUS_W     = 14,
  parameter int NUM_RANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [2:0]           req_size,
  input logic                 req_col_phase,
  input logic [NUM_RANKS-1:0] sd_cs_n,
  input logic [BUS_W-1:0]     sd_addr,
  input logic [1:0]           sd_bank
);
  // R2
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (sd_cs_n == '1 && sd_addr == '0 && sd_bank == 2'b00));

  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($countones(~sd_cs_n) == 1));

  // R4
  bank_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (sd_bank[0] == $past(req_addr[5])));

  // R8
  hi_lines_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size < 3'd4) |=> (sd_addr[13:12] == 2'b00 && sd_bank[1] == 1'b0));

  // R8
  line12_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size >= 3'd4) |=> (sd_addr[12] == $past(req_addr[11])));

  // R9
  line13_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_col_phase) |=> (sd_addr[13] == 1'b0));

  // R5
  col_mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_col_phase) |=> (sd_addr[11:8] == 4'b0000));
endmodule

bind sdram_addr_map sdram_addr_map_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NUM_RANKS(NUM_RANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .req_col_phase(req_col_phase),
  .sd_cs_n(sd_cs_n), .sd_addr(sd_addr), .sd_bank(sd_bank)
);

// File: tb/sdram_addr_map_tb_top.sv
`timescale 1ns/1ps
module sdram_addr_map_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_col_phase = 1'b0;
  logic [3:0]  sd_cs_n;
  logic [13:0] sd_addr;
  logic [1:0]  sd_bank;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  sdram_addr_map dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_col_phase(req_col_phase),
    .sd_cs_n(sd_cs_n), .sd_addr(sd_addr), .sd_bank(sd_bank)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference derived from the requirements
  task automatic model(input bit v, input int a, input int s, input bit p,
                       output int cs, output int bus, output int bk, output string btag);
    int k;
    int r;
    k = (s > 5) ? 5 : s;  // R10
    cs = 15; bus = 0; bk = 0; btag = "R2";
    if (!v) return;
    r  = (a >> (19 + k)) & 3;
    cs = 15 & ~(1 << r);
    bk = (a >> 5) & 1;
    if (k >= 4) bk = bk + (((a >> 11) & 1) * 2);
    if (p) begin
      btag = "R5";
      bus = (((a >> 6) & 31) * 8) + ((a >> 2) & 7);
      if (k >= 4) bus = bus + (((a >> 11) & 1) * 4096);
    end else if (k < 4) begin
      btag = "R6";
      bus = (a >> 11) % (1 << (8 + k));
    end else begin
      btag = "R7";
      bus = (a >> (8 + k)) & 2047;
      bus = bus + (((a >> 11) & 1) * 4096);
      if (k == 5) bus = bus + (((a >> 12) & 1) * 8192);
    end
  endtask

  task automatic step(input string tag, input bit v, input int a, input int s, input bit p);
    int ecs, ebus, ebk;
    string bt;
    req_valid = v; req_addr = 26'(a); req_size = 3'(s); req_col_phase = p;
    @(posedge clk);
    @(negedge clk);
    model(v, a, s, p, ecs, ebus, ebk, bt);
    check({tag, " cs R3"}, int'(sd_cs_n), ecs);
    check({tag, " bus ", bt}, int'(sd_addr), ebus);
    check({tag, " bank R4"}, int'(sd_bank), ebk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c, e0, e1, e2;
    string bt;
    // R2 reset state
    req_valid = 1'b1; req_addr = 26'h3ff_ffff;
    repeat (3) @(negedge clk);
    check("R2 reset cs", int'(sd_cs_n), 15);
    check("R2 reset bus", int'(sd_addr), 0);
    check("R2 reset bank", int'(sd_bank), 0);
    rst_n = 1'b1;
    step("R2 idle", 0, 26'h3ff_ffff, 5, 0);

    // R1: an input change does not reach outputs before the edge
    step("R1 base", 1, 32'h0000_0820, 0, 0);
    req_addr = 26'h3ff_ffff; req_col_phase = 1'b1; req_size = 3'd5;
    #1;
    model(1, 32'h0000_0820, 0, 0, e0, e1, e2, bt);
    check("R1 hold bus", int'(sd_addr), e1);
    check("R1 hold cs", int'(sd_cs_n), e0);

    // R3 every rank at every size, plus bits above the field (wrap)
    for (int s = 0; s < 6; s++)
      for (int r = 0; r < 4; r++) begin
        step("R3 rank", 1, r << (19 + s), s, 0);
        step("R3 wrap", 1, (r << (19 + s)) | (26'h3ff_ffff & ~((1 << (21 + s)) - 1)), s, 1);
      end

    // R5 R6 R7 R8 R9 patterns per size and phase
    for (int s = 0; s < 8; s++)
      for (int ph = 0; ph < 2; ph++) begin
        step("R6/R7 ones", 1, 26'h3ff_ffff, s, ph[0]);
        step("R8 bit11", 1, 26'h000_0800, s, ph[0]);
        step("R9 bit12", 1, 26'h000_1000, s, ph[0]);
        step("R5 alt", 1, 26'h2aa_aaaa, s, ph[0]);
        step("R5 alt2", 1, 26'h155_5555, s, ph[0]);
      end

    // R10 reserved codes equal 16 MB
    step("R10 code6", 1, 26'h2d3_5a7c, 6, 0);
    c = int'(sd_addr);
    step("R10 code5", 1, 26'h2d3_5a7c, 5, 0);
    check("R10 code6 vs 5", c, int'(sd_addr));

    // R11 byte offset ignored
    step("R11 off0", 1, 26'h1234_560, 2, 1);
    c = int'(sd_addr);
    step("R11 off3", 1, 26'h1234_563, 2, 1);
    check("R11 byte offset", int'(sd_addr), c);

    // Mixed random traffic, with idle cycles
    for (int i = 0; i < 3000; i++)
      step("rand", ($urandom % 5) != 0, int'($urandom % (1 << 26)), int'($urandom % 8),
           bit'($urandom % 2));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule